// File: doc/BRIEF.md
# USB Controller Interrupt Wrapper

This block gathers the event lines of a USB on-the-go core into one raw interrupt source word and gives software a small register window onto it. Each hardware event is a one-cycle pulse that latches its own source bit. Software can force source bits high through a set alias and acknowledge them through a clear alias. A mask register, which also has its own set and clear aliases, chooses which latched events may raise the single level interrupt line. A read-only view shows the source bits that pass the mask.

The interrupt line fires only while the wrapper is armed. Once the line has been raised, it cannot rise again until software writes any value to the end-of-interrupt offset. Reset leaves the wrapper armed, so the first enabled event fires. The control register also carries a soft-reset command for the neighbouring core. Each write cycle with bit 0 set produces a one-cycle pulse. A revision word and a status word complete the window.

Top module: `usbirq_wrap`

## Requirements
- R1: A read of 0x00 returns the nonzero REVISION parameter. A read of 0x04 (control) returns 0. A read of 0x08 (status) returns `vbus_drv_i` in bit 0 and zeros in all other bits. Any unmapped offset reads 0.
- R2: 0x20 reads the raw source word, 0x2C reads the mask word and 0x38 reads the masked view. The set and clear aliases sit at 0x24/0x28 for the source and 0x30/0x34 for the mask. The end-of-interrupt offset is 0x3C.
- R3: Source bit layout: `tx_evt[i]` goes to bit i (bits 4:0) and `rx_evt[j]` goes to bit 9+j (bits 12:9). `core_evt[k]` goes to bit 16+k (bits 24:16), so bit 24 is the VBUS-drive change event. Bit 8 and every bit not listed always read 0, in both source and mask.
- R4: A write to 0x24 sets each valid source bit that has a 1 in the write data and leaves the other bits unchanged.
- R5: A write to 0x28 clears each source bit that has a 1 in the write data and leaves the other bits unchanged.
- R6: A write to 0x30 sets mask bits and a write to 0x34 clears mask bits, one for each 1 in the write data.
- R7: The masked view equals the raw source AND the mask.
- R8: If a hardware event pulse and a software clear of the same bit fall in one cycle, the bit ends up set.
- R9: While armed, `irq_out` rises one clock after the masked view becomes nonzero. It falls one clock after the masked view becomes zero.
- R10: Once `irq_out` has risen, it does not rise again until an end-of-interrupt write with any data. The clock after that write, a nonzero masked view raises it again.
- R11: After reset the source and mask are 0, `irq_out` and `core_soft_rst` are 0, and the wrapper is armed.
- R12: Each write cycle to 0x04 with data bit 0 set gives a one-cycle `core_soft_rst` pulse in the following clock. A write with bit 0 clear gives no pulse.
- R13: Writes to 0x00, 0x08, 0x20, 0x2C, 0x38 and unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| tx_evt | input | NUM_TX (5) | Transmit endpoint event pulses |
| rx_evt | input | NUM_RX (4) | Receive endpoint event pulses |
| core_evt | input | NUM_CORE (9) | Core and bus event pulses |
| vbus_drv_i | input | 1 | VBUS drive level, shown in the status word |
| core_soft_rst | output | 1 | Soft-reset pulse to the USB core |
| irq_out | output | 1 | Level interrupt request |

## Verification
Two collisions can happen in one cycle. The first is a hardware event pulse arriving in the same cycle that software clears the same source bit. The bench provokes it by raising `rx_evt[1]` during a clear write that covers bit 10 and also bit 4. It then expects bit 10 to survive and bit 4 to go. The second collision is an end-of-interrupt write while an event is pending after the line was already taken. The bench checks that the line stays low until that write and rises exactly one clock after it.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   localparam int unsigned OFS_W = 8;

   localparam logic [OFS_W-1:0] OFS_REV      = 8'h00;
   localparam logic [OFS_W-1:0] OFS_CTL      = 8'h04;
   localparam logic [OFS_W-1:0] OFS_STAT     = 8'h08;
   localparam logic [OFS_W-1:0] OFS_SRC      = 8'h20;
   localparam logic [OFS_W-1:0] OFS_SRC_SET  = 8'h24;
   localparam logic [OFS_W-1:0] OFS_SRC_CLR  = 8'h28;
   localparam logic [OFS_W-1:0] OFS_MSK      = 8'h2C;
   localparam logic [OFS_W-1:0] OFS_MSK_SET  = 8'h30;
   localparam logic [OFS_W-1:0] OFS_MSK_CLR  = 8'h34;
   localparam logic [OFS_W-1:0] OFS_MASKED   = 8'h38;
   localparam logic [OFS_W-1:0] OFS_EOI      = 8'h3C;

   typedef struct packed {
      logic src_set;
      logic src_clr;
      logic msk_set;
      logic msk_clr;
      logic eoi;
      logic ctl;
   } wr_strobe_t;
endpackage

// File: rtl/usbirq_regdec.sv
module usbirq_regdec
   import usbirq_pkg::*;
#(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic          we,
   output wr_strobe_t    stb
);
   function automatic logic hit(input logic [AW-1:0] a, input logic [OFS_W-1:0] o);
      return a == AW'(o);
   endfunction

   always_comb begin
      stb         = '0;
      stb.src_set = we && hit(addr, OFS_SRC_SET);
      stb.src_clr = we && hit(addr, OFS_SRC_CLR);
      stb.msk_set = we && hit(addr, OFS_MSK_SET);
      stb.msk_clr = we && hit(addr, OFS_MSK_CLR);
      stb.eoi     = we && hit(addr, OFS_EOI);
      stb.ctl     = we && hit(addr, OFS_CTL);
   end

   // R13: a single access drives at most one write action
   a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stb));
   a_r13_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !we |-> (stb == '0));
endmodule

// File: rtl/usbirq_screg.sv
module usbirq_screg #(
   parameter int unsigned      W          = 32,
   parameter logic [W-1:0]     VALID      = '1,
   parameter bit               HAS_HW     = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] clr_v,
   input  logic [W-1:0] hw_v,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;
   logic [W-1:0] hw_eff;

   generate
      if (HAS_HW) begin : g_hw
         assign hw_eff = hw_v & VALID;
         always_comb nxt = ((q | (set_v & VALID) | hw_eff) & ~(clr_v & ~hw_eff)) & VALID;
      end else begin : g_sw
         assign hw_eff = '0;
         always_comb nxt = ((q | (set_v & VALID)) & ~clr_v) & VALID;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R4 / R6: requested set bits are high the next cycle
   a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & $past(set_v & VALID & ~clr_v)) == $past(set_v & VALID & ~clr_v)));
   // R5 / R6: cleared bits without a hardware event are low the next cycle
   a_r5_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & $past(clr_v & ~hw_eff)) == '0));
   // R8: hardware event wins over a software clear
   a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & $past(hw_eff)) == $past(hw_eff)));
   // R3: bits outside the layout never set
   a_r3_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (q & ~VALID) == '0);
endmodule

// File: rtl/usbirq_gate.sv
module usbirq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic eoi_wr,
   output logic irq
);
   logic armed;
   logic fire;

   assign fire = armed && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b1;
         irq   <= 1'b0;
      end else begin
         irq <= fire || (irq && pend);
         if (eoi_wr)    armed <= 1'b1;
         else if (fire) armed <= 1'b0;
      end
   end

   // R10: a disarmed, low line stays low without an end-of-interrupt write
   a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !irq && !eoi_wr) |=> !irq);
   // R10: a rise is always consumed from the armed state
   a_r10_rise_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq) && !$past(eoi_wr)) |-> !armed);
   // R9: nothing pending means the line drops next cycle
   a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> !irq);
   // R9: armed and pending raises the line next cycle
   a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && pend) |=> irq);
endmodule

// File: rtl/usbirq_wrap.sv
module usbirq_wrap
   import usbirq_pkg::*;
#(
   parameter int unsigned   AW       = 8,
   parameter int unsigned   DW       = 32,
   parameter int unsigned   NUM_TX   = 5,
   parameter int unsigned   NUM_RX   = 4,
   parameter int unsigned   RX_EP0   = 8,
   parameter int unsigned   NUM_CORE = 9,
   parameter int unsigned   CORE_LSB = 16,
   parameter logic [31:0]   REVISION = 32'h4E31_0107
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [AW-1:0]       bus_addr,
   input  logic                bus_we,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NUM_TX-1:0]   tx_evt,
   input  logic [NUM_RX-1:0]   rx_evt,
   input  logic [NUM_CORE-1:0] core_evt,
   input  logic                vbus_drv_i,
   output logic                core_soft_rst,
   output logic                irq_out
);
   localparam int unsigned RX_LSB = RX_EP0 + 1;
   localparam logic [DW-1:0] TX_FIELD   = DW'((64'd1 << NUM_TX) - 1);
   localparam logic [DW-1:0] RX_FIELD   = DW'(((64'd1 << NUM_RX) - 1) << RX_LSB);
   localparam logic [DW-1:0] CORE_FIELD = DW'(((64'd1 << NUM_CORE) - 1) << CORE_LSB);
   localparam logic [DW-1:0] VALID      = TX_FIELD | RX_FIELD | CORE_FIELD;

   generate
      if (AW < OFS_W)                     begin : g_chk_aw   $error("AW too small for the map"); end
      if (DW < 32)                        begin : g_chk_dw   $error("DW must be at least 32"); end
      if (NUM_TX > RX_EP0)                begin : g_chk_tx   $error("tx field overlaps rx field"); end
      if (RX_LSB + NUM_RX > CORE_LSB)     begin : g_chk_rx   $error("rx field overlaps core field"); end
      if (CORE_LSB + NUM_CORE > DW)       begin : g_chk_core $error("core field exceeds word"); end
      if (REVISION == 32'd0)              begin : g_chk_rev  $error("revision must be nonzero"); end
   endgenerate

   wr_strobe_t   stb;
   logic [DW-1:0] hw_vec;
   logic [DW-1:0] src_q;
   logic [DW-1:0] msk_q;
   logic [DW-1:0] masked;
   logic          soft_q;

   usbirq_regdec #(.AW(AW)) u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (bus_addr),
      .we    (bus_we),
      .stb   (stb)
   );

   always_comb begin
      hw_vec = DW'(tx_evt) | (DW'(rx_evt) << RX_LSB) | (DW'(core_evt) << CORE_LSB);
   end

   usbirq_screg #(.W(DW), .VALID(VALID), .HAS_HW(1'b1)) u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (stb.src_set ? bus_wdata : '0),
      .clr_v (stb.src_clr ? bus_wdata : '0),
      .hw_v  (hw_vec),
      .q     (src_q)
   );

   usbirq_screg #(.W(DW), .VALID(VALID), .HAS_HW(1'b0)) u_msk (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (stb.msk_set ? bus_wdata : '0),
      .clr_v (stb.msk_clr ? bus_wdata : '0),
      .hw_v  ('0),
      .q     (msk_q)
   );

   assign masked = src_q & msk_q;

   usbirq_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend   (|masked),
      .eoi_wr (stb.eoi),
      .irq    (irq_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) soft_q <= 1'b0;
      else        soft_q <= stb.ctl && bus_wdata[0];
   end
   assign core_soft_rst = soft_q;

   always_comb begin
      bus_rdata = '0;
      if      (bus_addr == AW'(OFS_REV))    bus_rdata = DW'(REVISION);
      else if (bus_addr == AW'(OFS_STAT))   bus_rdata = DW'(vbus_drv_i);
      else if (bus_addr == AW'(OFS_SRC))    bus_rdata = src_q;
      else if (bus_addr == AW'(OFS_MSK))    bus_rdata = msk_q;
      else if (bus_addr == AW'(OFS_MASKED)) bus_rdata = masked;
   end

   // R12: a pulse traces back to a control write with bit 0 set
   a_r12_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      core_soft_rst |-> $past(bus_we && bus_addr == AW'(OFS_CTL) && bus_wdata[0]));
   // R13: read-only offsets leave source and mask unchanged
   a_r13_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == AW'(OFS_SRC) || bus_addr == AW'(OFS_MSK)) && hw_vec == '0)
      |=> ($stable(src_q) && $stable(msk_q)));
   // R7: line high implies a masked bit was pending the cycle before
   a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ($past(masked) != '0));
endmodule

// File: tb/tb_usbirq_wrap.sv
module tb_usbirq_wrap;
   localparam logic [31:0] REV = 32'h4E31_0107;
   localparam logic [31:0] ALLV = 32'h01FF_1E1F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  tx_evt = '0;
   logic [3:0]  rx_evt = '0;
   logic [8:0]  core_evt = '0;
   logic        vbus_drv_i = 1'b0;
   logic        core_soft_rst;
   logic        irq_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   usbirq_wrap #(.REVISION(REV)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .core_evt(core_evt), .vbus_drv_i(vbus_drv_i),
      .core_soft_rst(core_soft_rst), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #0.5;
      chk(req, bus_rdata, exp);
   endtask

   task automatic pulse(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
      @(negedge clk);
      tx_evt = t; rx_evt = r; core_evt = c;
      @(negedge clk);
      tx_evt = '0; rx_evt = '0; core_evt = '0;
   endtask

   // {write addr, write data, read addr, expected read}
   localparam int NV = 10;
   localparam logic [79:0] VEC [NV] = '{
      {8'h30, 32'h0000_0003, 8'h2C, 32'h0000_0003},   // R6 mask set
      {8'h24, 32'hFFFF_FFFF, 8'h20, ALLV},            // R4 R3 set all
      {8'h28, 32'h0000_1E00, 8'h20, 32'h01FF_001F},   // R5 clear rx
      {8'h34, 32'h0000_0001, 8'h38, 32'h0000_0002},   // R6 R7 mask clear, masked view
      {8'h30, 32'hFFFF_FFFF, 8'h2C, ALLV},            // R3 R6 mask layout
      {8'h20, 32'h0000_0000, 8'h20, 32'h01FF_001F},   // R13 raw source read-only
      {8'h2C, 32'h0000_0000, 8'h2C, ALLV},            // R13 mask read-only
      {8'h28, 32'hFFFF_FFFF, 8'h38, 32'h0000_0000},   // R5 R7 clear all
      {8'h00, 32'h0000_0000, 8'h00, REV},             // R1 R13 revision
      {8'h38, 32'h0000_FFFF, 8'h44, 32'h0000_0000}    // R1 R13 unmapped
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      rd("R11 src", 8'h20, 32'h0);
      rd("R11 mask", 8'h2C, 32'h0);
      rd("R11 masked", 8'h38, 32'h0);
      chk("R11 irq", 32'(irq_out), 32'h0);
      chk("R11 softrst", 32'(core_soft_rst), 32'h0);
      // R11 armed: first event fires
      wr(8'h30, 32'h1);
      pulse(5'h01, 4'h0, 9'h0);
      chk("R9 irq latency low", 32'(irq_out), 32'h0);
      @(negedge clk);
      chk("R11 first fire", 32'(irq_out), 32'h1);
      wr(8'h28, 32'h1);
      @(negedge clk);
      chk("R9 drop", 32'(irq_out), 32'h0);

      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][79:72], VEC[i][71:40]);
         rd($sformatf("R2 vec%0d", i), VEC[i][39:32], VEC[i][31:0]);
      end

      // R3 core top bit, R10 no re-rise without EOI
      pulse(5'h0, 4'h0, 9'h100);
      rd("R3 vbus-drive bit", 8'h20, 32'h0100_0000);
      @(negedge clk);
      chk("R10 held off", 32'(irq_out), 32'h0);
      wr(8'h3C, 32'h0000_1234);
      chk("R10 before eoi effect", 32'(irq_out), 32'h0);
      @(negedge clk);
      chk("R10 eoi rearm", 32'(irq_out), 32'h1);
      wr(8'h28, 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R9 fall", 32'(irq_out), 32'h0);
      pulse(5'h0, 4'h8, 9'h0);
      rd("R3 rx3 bit", 8'h20, 32'h0000_1000);
      @(negedge clk); @(negedge clk);
      chk("R10 second event held", 32'(irq_out), 32'h0);
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h3C, 32'h0);
      @(negedge clk); @(negedge clk);
      chk("R10 armed idle", 32'(irq_out), 32'h0);
      pulse(5'h10, 4'h0, 9'h0);
      chk("R9 one-cycle delay", 32'(irq_out), 32'h0);
      @(negedge clk);
      chk("R9 rise", 32'(irq_out), 32'h1);
      rd("R7 masked tx4", 8'h38, 32'h0000_0010);

      // R8: hardware event and software clear collide
      @(negedge clk);
      rx_evt = 4'h2; bus_addr = 8'h28; bus_we = 1'b1; bus_wdata = 32'h0000_0410;
      @(negedge clk);
      rx_evt = '0; bus_we = 1'b0; bus_wdata = '0;
      rd("R8 hw beats clear", 8'h20, 32'h0000_0400);

      // R12 soft reset
      wr(8'h04, 32'h1);
      chk("R12 pulse", 32'(core_soft_rst), 32'h1);
      @(negedge clk);
      chk("R12 one cycle", 32'(core_soft_rst), 32'h0);
      wr(8'h04, 32'h2);
      chk("R12 no pulse", 32'(core_soft_rst), 32'h0);
      rd("R1 ctl reads 0", 8'h04, 32'h0);

      // R1 status
      vbus_drv_i = 1'b1;
      rd("R1 status high", 8'h08, 32'h1);
      vbus_drv_i = 1'b0;
      rd("R1 status low", 8'h08, 32'h0);
      wr(8'h08, 32'hFFFF_FFFF);
      rd("R13 src after ro writes", 8'h20, 32'h0000_0400);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule